// File: doc/BRIEF.md
# I2C Own-Address Match Detector

This block listens on the SCL and SDA lines of an I2C bus. After a START condition it gathers the next byte. The first seven bits arrive most significant bit first, and the eighth bit gives the transfer direction. The block compares those seven bits with an address that software has programmed. When the module is enabled and the address matches, the block does four things:

- It acknowledges in the ninth clock, using an acknowledge level that software chooses.
- It latches a sticky match flag.
- It forces the master-role control bit to zero.
- It requests an interrupt, if the match interrupt is enabled.

Software uses a small byte-wide register port with four locations, selected by a 2-bit select:

| Select | Register | Contents |
|---|---|---|
| 0 | Own address | bits 6..0 hold the address |
| 1 | Control | bit 0 enable, bit 1 master role, bit 2 not-acknowledge select |
| 2 | Status | bit 0 match flag |
| 3 | Interrupt enable | bit 0 match interrupt enable |

The SDA drive is a pull-low output only. An open-drain pad outside the block combines it with the bus.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset all four registers read as zero. Bits 6..0 of the own-address register can be written and read back. Bit 7 of that register always reads 0.
- R2: After a START, the block samples SDA on each of the next eight SCL rising edges, most significant bit first. The first seven bits form the address. The eighth bit is the direction, and it does not affect the comparison.
- R3: When the address matches while enable (control bit 0) is 1, status bit 0 becomes 1. This happens on the SCL falling edge that follows the eighth bit.
- R4: A match clears control bit 1, the master role.
- R5: Control bit 2 selects the acknowledge level. When it is 0 on a match, sda_pull_o is asserted from the SCL fall after the eighth bit until the SCL fall that ends the ninth clock. When it is 1, sda_pull_o stays low.
- R6: While enable is 0, the block never sets the flag or pulls SDA, even when the address is equal.
- R7: irq_o is high exactly when the match flag and interrupt-enable bit 0 are both 1.
- R8: The match flag remains set until software writes 0 to status bit 0. Writing 1 to that bit has no effect.
- R9: A mismatch leaves the flag clear, leaves sda_pull_o low, and leaves the master bit unchanged.
- R10: A STOP during the address byte abandons that byte, and bits clocked after it give no match. A repeated START restarts address capture from the first bit.
- R11: When a match happens in the same clock as a software write that clears the flag or sets the master bit, the match wins: the flag reads 1 and the master bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 8 | Read data of the selected register |
| sda_pull_o | output | 1 | Drives SDA low when 1 |
| irq_o | output | 1 | Match interrupt request |

## Verification
Two updates can land in the same clock. The hardware match event sets the flag and clears the master bit. A software register write can try to clear the flag or set the master bit at that same moment. The bench provokes this by counting the two synchronizer stages and the edge-detect register from its final SCL fall, and it times a single-cycle write to land on exactly that edge. It then judges the outcome by reading back the status and control registers: the flag must read 1 and the master bit must read 0.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data,
  output logic       sda_pull_o,
  output logic       irq_o
);
  localparam int BYTE_BITS = ADDR_W + 1;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_ACK, S_WAIT} state_t;

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, sda_s, scl_p, sda_p;
  logic start_det, stop_det, scl_rise, scl_fall;

  state_t               state;
  logic [CNT_W-1:0]     cnt;
  logic [BYTE_BITS-1:0] shreg;
  logic [ADDR_W-1:0]    own_addr;
  logic en, master, nack, ie, match_flag, ack_drive, match_ev;

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;

  assign match_ev = en && state == S_ADDR && cnt == CNT_W'(BYTE_BITS) && scl_fall &&
                    shreg[BYTE_BITS-1:1] == own_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      shreg <= '0;
    end else if (!en || stop_det) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else if (start_det) begin
      state <= S_ADDR;
      cnt   <= '0;
    end else begin
      case (state)
        S_ADDR: begin
          if (scl_rise && cnt < CNT_W'(BYTE_BITS)) begin
            shreg <= {shreg[BYTE_BITS-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_W'(BYTE_BITS)) begin
            state <= match_ev ? S_ACK : S_WAIT;
            cnt   <= '0;
          end
        end
        S_ACK: begin
          if (scl_rise) cnt <= 1'b1;
          else if (scl_fall && cnt != '0) state <= S_WAIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_addr   <= '0;
      en         <= 1'b0;
      master     <= 1'b0;
      nack       <= 1'b0;
      ie         <= 1'b0;
      match_flag <= 1'b0;
      ack_drive  <= 1'b0;
    end else begin
      if (wr_en && wr_sel == 2'd0) own_addr <= wr_data[ADDR_W-1:0];
      if (wr_en && wr_sel == 2'd1) {nack, master, en} <= wr_data[2:0];
      if (wr_en && wr_sel == 2'd3) ie <= wr_data[0];
      if (wr_en && wr_sel == 2'd2 && !wr_data[0]) match_flag <= 1'b0;
      if (match_ev) begin
        match_flag <= 1'b1;
        master     <= 1'b0;
        ack_drive  <= ~nack;
      end
    end
  end

  assign sda_pull_o = (state == S_ACK) & ack_drive;
  assign irq_o      = match_flag & ie;

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = {{(8-ADDR_W){1'b0}}, own_addr};
      2'd1:    rd_data = {5'b0, nack, master, en};
      2'd2:    rd_data = {7'b0, match_flag};
      default: rd_data = {7'b0, ie};
    endcase
  end
endmodule

module i2c_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       match_flag,
  input logic       master,
  input logic       en,
  input logic       nack,
  input logic       sda_pull_o,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [1:0] rd_sel,
  input logic [7:0] rd_data
);
  // R3
  pull_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> match_flag);
  // R5
  pull_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !$past(nack));
  // R4
  match_clears_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> !master);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag && !(wr_en && wr_sel == 2'd2 && !wr_data[0]) |=> match_flag);
  // R6
  disabled_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(match_flag));
  // R1
  addr_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel == 2'd0 |-> !rd_data[7]);
endmodule

bind i2c_addr_match i2c_addr_match_chk chk (
  .clk(clk), .rst_n(rst_n), .match_flag(match_flag), .master(master), .en(en),
  .nack(nack), .sda_pull_o(sda_pull_o), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
  localparam int H = 8;
  localparam int NV = 8;
  // fields: own[18:12] bus[11:5] rw[4] en[3] nack[2] ie[1] exp_match[0]
  localparam logic [18:0] VEC [NV] = '{
    {7'h08, 7'h08, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'h08, 7'h09, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {7'h55, 7'h55, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {7'h7F, 7'h7F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {7'h00, 7'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'h2A, 7'h2B, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {7'h40, 7'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {7'h01, 7'h40, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic sda_pull_o, irq_o;
  wire  sda_bus = sda_m & ~sda_pull_o;
  int checks = 0, fails = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  i2c_addr_match uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .sda_pull_o(sda_pull_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); rd_sel = s; #1 d = rd_data;
  endtask

  task automatic bus_start;
    sda_m = 1; scl_m = 1; hold(H);
    sda_m = 0; hold(H);
    scl_m = 0; hold(H);
  endtask

  task automatic bus_stop;
    sda_m = 0; hold(H);
    scl_m = 1; hold(H);
    sda_m = 1; hold(H);
  endtask

  task automatic bus_bit(input logic b);
    sda_m = b; hold(H);
    scl_m = 1; hold(H);
    scl_m = 0; hold(H);
  endtask

  task automatic send_byte(input logic [6:0] a, input logic rw);
    for (int i = 6; i >= 0; i--) bus_bit(a[i]);
    bus_bit(rw);
  endtask

  task automatic ack_slot(input logic exp_pull);
    sda_m = 1; hold(H);
    chk("R5 pull in ack low phase", {7'b0, sda_pull_o}, {7'b0, exp_pull});
    scl_m = 1; hold(H);
    chk("R5 pull in ack high phase", {7'b0, sda_pull_o}, {7'b0, exp_pull});
    scl_m = 0; hold(H);
    chk("R5 pull released after ninth clock", {7'b0, sda_pull_o}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    hold(3); rst_n = 1; hold(2);
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v); chk("R1 reset register value", v, 8'h00);
    end
    chk("R7 irq low after reset", {7'b0, irq_o}, 8'h00);
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R1 bit 7 reads zero", v, 8'h7F);

    for (int k = 0; k < NV; k++) begin
      logic [18:0] t;
      logic m, p, q;
      t = VEC[k];
      m = t[0];
      p = m & ~t[2];
      q = m & t[1];
      wr(2'd2, 8'h00);
      wr(2'd0, {1'b0, t[18:12]});
      wr(2'd1, {5'b0, t[2], 1'b1, t[3]});
      wr(2'd3, {7'b0, t[1]});
      bus_start;
      send_byte(t[11:5], t[4]);
      ack_slot(p);
      bus_stop;
      rd(2'd2, v); chk("R2 R3 R6 R9 match flag", v, {7'b0, m});
      rd(2'd1, v); chk("R4 R9 master bit", v, {5'b0, t[2], ~m, t[3]});
      chk("R7 irq", {7'b0, irq_o}, {7'b0, q});
    end

    // R8 sticky flag
    wr(2'd0, 8'h3C); wr(2'd1, 8'h03); wr(2'd3, 8'h01);
    bus_start; send_byte(7'h3C, 1'b0); ack_slot(1'b1); bus_stop;
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R8 writing 1 keeps flag", v, 8'h01);
    chk("R7 irq with flag and enable", {7'b0, irq_o}, 8'h01);
    wr(2'd3, 8'h00);
    chk("R7 irq masked", {7'b0, irq_o}, 8'h00);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R8 writing 0 clears flag", v, 8'h00);

    // R10 stop mid-address then bits without a start
    wr(2'd1, 8'h03);
    bus_start; bus_bit(0); bus_bit(1); bus_bit(1);
    bus_stop;
    scl_m = 0; hold(H);
    send_byte(7'h3C, 1'b0); ack_slot(1'b0);
    sda_m = 1; scl_m = 1; hold(H);
    rd(2'd2, v); chk("R10 no match after stop", v, 8'h00);
    // R10 repeated start restarts capture
    bus_start; bus_bit(1); bus_bit(1); bus_bit(0);
    sda_m = 1; hold(H); scl_m = 1; hold(H);
    bus_start; send_byte(7'h3C, 1'b1); ack_slot(1'b1); bus_stop;
    rd(2'd2, v); chk("R10 match after repeated start", v, 8'h01);

    // R11 match coincides with software writes
    for (int j = 0; j < 2; j++) begin
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h03);
      bus_start;
      for (int i = 6; i >= 0; i--) bus_bit(7'h3C >> i);
      sda_m = 0; hold(H); scl_m = 1; hold(H);
      @(negedge clk); scl_m = 0;
      @(posedge clk); @(posedge clk);
      @(negedge clk); wr_en = 1;
      wr_sel = (j == 0) ? 2'd2 : 2'd1;
      wr_data = (j == 0) ? 8'h00 : 8'h03;
      @(negedge clk); wr_en = 0;
      hold(H);
      ack_slot(1'b1);
      bus_stop;
      rd(2'd2, v); chk("R11 flag wins over same-cycle write", v, 8'h01);
      rd(2'd1, v); chk("R11 master cleared despite same-cycle write", v, 8'h01);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule